// File: doc/BRIEF.md
# Coprocessor Transfer Controller (CPU side)

This block is the CPU-pipeline end of a coprocessor link. An instruction arrives from the pipeline together with its condition result, its direction and its register operands. The controller puts the instruction on the coprocessor bus for one decode cycle and then one execute cycle. It signals a request with an active-low strobe and reports whether the condition passed. It then watches the coprocessor's answer. In the first execute cycle that answer comes on a decode-timed handshake bus. In each later execute cycle it comes on an execute-timed handshake bus.

While the coprocessor answers WAIT or GO, the controller holds the pipeline with a stall output. When LAST is seen, the instruction commits. Data then moves at fixed stages:
- **Register-to-coprocessor move:** outbound data is driven during the write stage.
- **Coprocessor-to-register move:** inbound data is captured at the end of the memory stage and written back one cycle later, through a write enable with a destination index.

An ABSENT answer aborts the instruction with a one-cycle undefined-instruction pulse. A failed condition retires the instruction silently. Only one instruction is in flight at a time.

Top module: `cpx_xfer_ctrl`

## Requirements
- R1: While and after a synchronous reset the outputs rest as follows: `cp_req_n`=1, and `cp_pass`, `stall`, `commit`, `undef`, `rf_we` and `cp_dout` are all 0.
- R2: A request (`issue_vld`=1) is taken only at a clock edge where the controller is idle. The next cycle is the decode cycle, and `cp_instr` shows the word that was taken. `issue_vld` and the operand inputs at any other edge have no effect.
- R3: `cp_req_n` is low in the decode cycle and in the first execute cycle, and high in every other cycle, including later execute cycles.
- R4: `cp_pass` is 1 only in the first execute cycle, and only when `issue_cond` was 1 when the request was taken.
- R5: Handshake codes are 2'b00 ABSENT, 2'b01 WAIT, 2'b10 GO and 2'b11 LAST. `cp_hs_dec` is examined only in the first execute cycle with `cp_pass`=1. `cp_hs_exe` is examined only in later execute cycles. Both are ignored at all other times.
- R6: `stall` is 1, in the same cycle, during any execute cycle whose examined code is WAIT or GO. It is 0 in the cycle LAST is seen and in all other cycles.
- R7: After LAST is seen, `commit` is 1 for exactly the next cycle, which is the memory stage.
- R8: After ABSENT is seen, `undef` is 1 for exactly the next cycle. No commit and no data transfer follow, and the controller is idle again.
- R9: When `cp_pass` is 0, the instruction retires with no stall, commit, undef or transfer, and the controller is idle in the next cycle.
- R10: For a register-to-coprocessor move (`issue_mrc`=0), `cp_dout` carries the `issue_src` value taken with the request for exactly the cycle after `commit` (the write stage). Otherwise `cp_dout` is 0.
- R11: For a coprocessor-to-register move (`issue_mrc`=1), `cp_din` is sampled at the end of the memory stage. In the next cycle `rf_we`=1, `rf_widx` is the taken `issue_rd` and `rf_wdata` is the sampled value.
- R12: Reset asserted during a transaction abandons it. The controller is idle in the next cycle and no commit follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | Pipeline offers an instruction |
| issue_instr | input | IW | Instruction word |
| issue_mrc | input | 1 | 1: coprocessor-to-register, 0: register-to-coprocessor |
| issue_cond | input | 1 | Condition codes allow execution |
| issue_rd | input | RW | Destination register index |
| issue_src | input | DW | Source register value |
| cp_req_n | output | 1 | Active-low request strobe |
| cp_instr | output | IW | Instruction presented to the coprocessor |
| cp_pass | output | 1 | Condition passed |
| cp_hs_dec | input | 2 | Decode-timed handshake |
| cp_hs_exe | input | 2 | Execute-timed handshake |
| cp_dout | output | DW | Outbound data bus |
| cp_din | input | DW | Inbound data bus |
| stall | output | 1 | Pipeline hold |
| commit | output | 1 | One-cycle commit pulse |
| undef | output | 1 | One-cycle undefined-instruction pulse |
| rf_we | output | 1 | Register write enable |
| rf_widx | output | RW | Register write index |
| rf_wdata | output | DW | Register write data |

## Verification
The bench builds the block with the defaults: 32-bit data and instruction words and 16 registers, which gives a 4-bit index. The vector table can therefore reach indices 0 and 15 and wait runs of up to fifteen cycles. During the ignored cycles it drives inverted operands and misleading handshake codes, so a design that samples at the wrong edge shows a wrong word, index or code at the ports. Both end codes are reached from the decode-timed bus and from the execute-timed bus.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

  typedef enum logic [1:0] {
    HS_ABSENT = 2'b00,
    HS_WAIT   = 2'b01,
    HS_GO     = 2'b10,
    HS_LAST   = 2'b11
  } cpx_hs_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEC  = 3'd1,
    ST_EXE1 = 3'd2,
    ST_EXEN = 3'd3,
    ST_MEM  = 3'd4,
    ST_WB   = 3'd5
  } cpx_st_e;

  function automatic logic hs_holds(input logic [1:0] code);
    return (code == HS_WAIT) || (code == HS_GO);
  endfunction

endpackage

// File: rtl/cpx_hs_seq.sv
module cpx_hs_seq
  import cpx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       issue_vld,
  input  logic       issue_cond,
  input  logic [1:0] hs_dec,
  input  logic [1:0] hs_exe,
  output cpx_st_e    st,
  output logic       accept,
  output logic       req_n,
  output logic       pass,
  output logic       stall,
  output logic       commit,
  output logic       undef
);

  cpx_st_e st_q, st_d;
  logic    cond_q;
  logic    undef_q, undef_d;
  logic [1:0] seen;
  logic    seen_vld;

  // Which handshake bus counts in this cycle.
  always_comb begin
    seen     = HS_ABSENT;
    seen_vld = 1'b0;
    if (st_q == ST_EXE1 && cond_q) begin
      seen     = hs_dec;
      seen_vld = 1'b1;
    end else if (st_q == ST_EXEN) begin
      seen     = hs_exe;
      seen_vld = 1'b1;
    end
  end

  always_comb begin
    st_d    = st_q;
    undef_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (issue_vld) st_d = ST_DEC;
      ST_DEC:  st_d = ST_EXE1;
      ST_EXE1, ST_EXEN: begin
        if (!seen_vld) begin
          st_d = ST_IDLE;
        end else if (seen == HS_LAST) begin
          st_d = ST_MEM;
        end else if (seen == HS_ABSENT) begin
          st_d    = ST_IDLE;
          undef_d = 1'b1;
        end else begin
          st_d = ST_EXEN;
        end
      end
      ST_MEM:  st_d = ST_WB;
      ST_WB:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cond_q  <= 1'b0;
      undef_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      undef_q <= undef_d;
      if (st_q == ST_IDLE && issue_vld) cond_q <= issue_cond;
    end
  end

  assign st     = st_q;
  assign accept = (st_q == ST_IDLE) && issue_vld;
  assign req_n  = !((st_q == ST_DEC) || (st_q == ST_EXE1));
  assign pass   = (st_q == ST_EXE1) && cond_q;
  assign stall  = seen_vld && hs_holds(seen);
  assign commit = (st_q == ST_MEM);
  assign undef  = undef_q;

endmodule

// File: rtl/cpx_data_stage.sv
module cpx_data_stage
  import cpx_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 32,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  cpx_st_e       st,
  input  logic [IW-1:0] issue_instr,
  input  logic          issue_mrc,
  input  logic [RW-1:0] issue_rd,
  input  logic [DW-1:0] issue_src,
  input  logic [DW-1:0] cp_din,
  output logic [IW-1:0] cp_instr,
  output logic [DW-1:0] cp_dout,
  output logic          rf_we,
  output logic [RW-1:0] rf_widx,
  output logic [DW-1:0] rf_wdata
);

  logic [IW-1:0] instr_q;
  logic          mrc_q;
  logic [RW-1:0] rd_q;
  logic [DW-1:0] src_q;

  // Operands are captured once, when the request is taken.
  always_ff @(posedge clk) begin
    if (rst) begin
      instr_q <= '0;
      mrc_q   <= 1'b0;
      rd_q    <= '0;
      src_q   <= '0;
    end else if (accept) begin
      instr_q <= issue_instr;
      mrc_q   <= issue_mrc;
      rd_q    <= issue_rd;
      src_q   <= issue_src;
    end
  end

  // Leaving the memory stage: load outbound data, or sample inbound data.
  always_ff @(posedge clk) begin
    if (rst) begin
      cp_dout  <= '0;
      rf_we    <= 1'b0;
      rf_widx  <= '0;
      rf_wdata <= '0;
    end else begin
      cp_dout <= (st == ST_MEM && !mrc_q) ? src_q : '0;
      rf_we   <= (st == ST_MEM) && mrc_q;
      if (st == ST_MEM && mrc_q) begin
        rf_widx  <= rd_q;
        rf_wdata <= cp_din;
      end
    end
  end

  assign cp_instr = instr_q;

endmodule

// File: rtl/cpx_xfer_ctrl.sv
module cpx_xfer_ctrl
  import cpx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int IW   = 32,
  parameter int NREG = 16,
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_vld,
  input  logic [IW-1:0] issue_instr,
  input  logic          issue_mrc,
  input  logic          issue_cond,
  input  logic [RW-1:0] issue_rd,
  input  logic [DW-1:0] issue_src,
  output logic          cp_req_n,
  output logic [IW-1:0] cp_instr,
  output logic          cp_pass,
  input  logic [1:0]    cp_hs_dec,
  input  logic [1:0]    cp_hs_exe,
  output logic [DW-1:0] cp_dout,
  input  logic [DW-1:0] cp_din,
  output logic          stall,
  output logic          commit,
  output logic          undef,
  output logic          rf_we,
  output logic [RW-1:0] rf_widx,
  output logic [DW-1:0] rf_wdata
);

  cpx_st_e st;
  logic    accept;

  cpx_hs_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .issue_vld  (issue_vld),
    .issue_cond (issue_cond),
    .hs_dec     (cp_hs_dec),
    .hs_exe     (cp_hs_exe),
    .st         (st),
    .accept     (accept),
    .req_n      (cp_req_n),
    .pass       (cp_pass),
    .stall      (stall),
    .commit     (commit),
    .undef      (undef)
  );

  cpx_data_stage #(.DW(DW), .IW(IW), .RW(RW)) u_data (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .st          (st),
    .issue_instr (issue_instr),
    .issue_mrc   (issue_mrc),
    .issue_rd    (issue_rd),
    .issue_src   (issue_src),
    .cp_din      (cp_din),
    .cp_instr    (cp_instr),
    .cp_dout     (cp_dout),
    .rf_we       (rf_we),
    .rf_widx     (rf_widx),
    .rf_wdata    (rf_wdata)
  );

endmodule

// File: rtl/cpx_xfer_ctrl_chk.sv
module cpx_xfer_ctrl_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cp_req_n,
  input logic          cp_pass,
  input logic          stall,
  input logic          commit,
  input logic          undef,
  input logic          rf_we,
  input logic [DW-1:0] cp_dout
);

  // R3
  req_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (!cp_req_n && $past(!cp_req_n)) |=> cp_req_n);

  // R4
  pass_slot_chk: assert property (@(posedge clk) disable iff (rst)
    cp_pass |-> (!cp_req_n && $past(!cp_req_n)));

  // R7
  commit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

  // R8
  undef_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    undef |=> !undef);

  // R8
  end_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(commit && undef));

  // R6
  stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> (!commit && !undef && !rf_we));

  // R11
  wb_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $past(commit));

  // R10
  dout_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_dout != '0) |-> $past(commit));

endmodule

bind cpx_xfer_ctrl cpx_xfer_ctrl_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cp_req_n (cp_req_n),
  .cp_pass  (cp_pass),
  .stall    (stall),
  .commit   (commit),
  .undef    (undef),
  .rf_we    (rf_we),
  .cp_dout  (cp_dout)
);

// File: tb/cpx_xfer_ctrl_bench.sv
module cpx_xfer_ctrl_bench;
  import cpx_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int IW = 32;
  localparam int NREG = 16;
  localparam int RW = 4;

  typedef struct packed {
    logic        mrc;
    logic        cond;
    logic [3:0]  nwait;
    logic        absent;
    logic [3:0]  rd;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 4'd0,  1'b0, 4'd3,  32'hA5A5_0001},
    '{1'b1, 1'b1, 4'd0,  1'b0, 4'd7,  32'h1234_5678},
    '{1'b0, 1'b1, 4'd3,  1'b0, 4'd1,  32'hDEAD_BEEF},
    '{1'b1, 1'b1, 4'd5,  1'b0, 4'd15, 32'h0F0F_F0F0},
    '{1'b1, 1'b0, 4'd2,  1'b0, 4'd2,  32'h5555_AAAA},
    '{1'b0, 1'b1, 4'd0,  1'b1, 4'd4,  32'h7777_0000},
    '{1'b1, 1'b1, 4'd2,  1'b1, 4'd9,  32'h0000_8888},
    '{1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  32'hCAFE_F00D},
    '{1'b1, 1'b1, 4'd15, 1'b0, 4'd0,  32'h8000_0001}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          issue_vld;
  logic [IW-1:0] issue_instr;
  logic          issue_mrc;
  logic          issue_cond;
  logic [RW-1:0] issue_rd;
  logic [DW-1:0] issue_src;
  logic          cp_req_n;
  logic [IW-1:0] cp_instr;
  logic          cp_pass;
  logic [1:0]    cp_hs_dec;
  logic [1:0]    cp_hs_exe;
  logic [DW-1:0] cp_dout;
  logic [DW-1:0] cp_din;
  logic          stall;
  logic          commit;
  logic          undef;
  logic          rf_we;
  logic [RW-1:0] rf_widx;
  logic [DW-1:0] rf_wdata;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpx_xfer_ctrl #(.DW(DW), .IW(IW), .NREG(NREG)) u_cpx_xfer_ctrl (
    .clk(clk), .rst(rst), .issue_vld(issue_vld), .issue_instr(issue_instr),
    .issue_mrc(issue_mrc), .issue_cond(issue_cond), .issue_rd(issue_rd),
    .issue_src(issue_src), .cp_req_n(cp_req_n), .cp_instr(cp_instr),
    .cp_pass(cp_pass), .cp_hs_dec(cp_hs_dec), .cp_hs_exe(cp_hs_exe),
    .cp_dout(cp_dout), .cp_din(cp_din), .stall(stall), .commit(commit),
    .undef(undef), .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] hold_code(input int k);
    return (k % 2 == 1) ? HS_GO : HS_WAIT;
  endfunction

  task automatic idle_checks(input string tag);
    chk({tag, " R3 req_n idle"}, 32'(cp_req_n), 32'd1);
    chk({tag, " R6 stall idle"}, 32'(stall), 32'd0);
    chk({tag, " R7 commit idle"}, 32'(commit), 32'd0);
    chk({tag, " R11 rf_we idle"}, 32'(rf_we), 32'd0);
    chk({tag, " R10 dout idle"}, cp_dout, 32'd0);
  endtask

  task automatic run_txn(input vec_t v, input logic [IW-1:0] ins);
    logic [1:0] endc;
    endc = v.absent ? HS_ABSENT : HS_LAST;
    issue_vld = 1'b1; issue_instr = ins; issue_mrc = v.mrc; issue_cond = v.cond;
    issue_rd = v.rd; issue_src = v.data;
    cp_hs_dec = HS_GO; cp_hs_exe = HS_GO; cp_din = ~v.data;
    // decode cycle
    @(posedge clk); #1;
    issue_instr = ~ins; issue_src = ~v.data; issue_rd = ~v.rd;
    issue_mrc = ~v.mrc; issue_cond = ~v.cond;
    cp_hs_dec = HS_ABSENT; cp_hs_exe = HS_ABSENT;
    #1;
    chk("R3 req_n decode", 32'(cp_req_n), 32'd0);
    chk("R2 cp_instr decode", cp_instr, ins);
    chk("R4 pass decode", 32'(cp_pass), 32'd0);
    chk("R6 stall decode", 32'(stall), 32'd0);
    // first execute cycle
    @(posedge clk); #1;
    cp_hs_dec = (v.nwait == 0) ? endc : hold_code(0);
    cp_hs_exe = HS_ABSENT;
    #1;
    chk("R3 req_n exe1", 32'(cp_req_n), 32'd0);
    chk("R4 pass exe1", 32'(cp_pass), 32'(v.cond));
    chk("R6 stall exe1", 32'(stall), 32'(v.cond && v.nwait != 0));
    chk("R2 cp_instr held", cp_instr, ins);
    if (!v.cond) begin
      @(posedge clk); #1; issue_vld = 1'b0; #1;
      chk("R9 undef after fail", 32'(undef), 32'd0);
      idle_checks("R9 fail+1");
      for (int j = 0; j < 3; j++) begin
        @(posedge clk); #2;
        idle_checks("R9 fail quiet");
      end
      return;
    end
    for (int k = 1; k <= v.nwait; k++) begin
      @(posedge clk); #1;
      cp_hs_dec = HS_LAST;
      cp_hs_exe = (k == v.nwait) ? endc : hold_code(k);
      #1;
      chk("R3 req_n later exe", 32'(cp_req_n), 32'd1);
      chk("R4 pass later exe", 32'(cp_pass), 32'd0);
      chk("R6 stall later exe", 32'(stall), 32'(k != v.nwait));
      chk("R5 commit during exe", 32'(commit), 32'd0);
    end
    @(posedge clk); #1;
    issue_vld = 1'b0; cp_hs_dec = HS_ABSENT; cp_hs_exe = HS_ABSENT; cp_din = v.data;
    #1;
    if (v.absent) begin
      chk("R8 undef pulse", 32'(undef), 32'd1);
      chk("R8 no commit", 32'(commit), 32'd0);
      chk("R8 stall", 32'(stall), 32'd0);
      @(posedge clk); #2;
      chk("R8 undef one cycle", 32'(undef), 32'd0);
      idle_checks("R8 after");
      @(posedge clk); #2;
      idle_checks("R8 idle");
      return;
    end
    chk("R7 commit pulse", 32'(commit), 32'd1);
    chk("R7 undef", 32'(undef), 32'd0);
    chk("R10 dout mem", cp_dout, 32'd0);
    chk("R11 rf_we mem", 32'(rf_we), 32'd0);
    @(posedge clk); #1; cp_din = ~v.data; #1;
    chk("R7 commit one cycle", 32'(commit), 32'd0);
    if (v.mrc) begin
      chk("R11 rf_we wb", 32'(rf_we), 32'd1);
      chk("R11 rf_widx", 32'(rf_widx), 32'(v.rd));
      chk("R11 rf_wdata", rf_wdata, v.data);
      chk("R10 dout on mrc", cp_dout, 32'd0);
    end else begin
      chk("R10 dout wb", cp_dout, v.data);
      chk("R11 rf_we on mcr", 32'(rf_we), 32'd0);
    end
    @(posedge clk); #2;
    idle_checks("R10 R11 after wb");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; issue_vld = 1'b0; issue_instr = '0; issue_mrc = 1'b0; issue_cond = 1'b0;
    issue_rd = '0; issue_src = '0; cp_hs_dec = HS_LAST; cp_hs_exe = HS_LAST; cp_din = '1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 req_n reset", 32'(cp_req_n), 32'd1);
    chk("R1 pass reset", 32'(cp_pass), 32'd0);
    chk("R1 undef reset", 32'(undef), 32'd0);
    idle_checks("R1 reset");
    @(posedge clk); #1; rst = 1'b0;
    @(posedge clk); #2;
    idle_checks("R1 after reset");
    chk("R2 no issue stays idle", 32'(cp_req_n), 32'd1);

    for (int i = 0; i < NV; i++) begin
      run_txn(VECS[i], 32'hC000_0000 | 32'(i));
    end

    // R12: reset in the middle of a stalled execute
    issue_vld = 1'b1; issue_instr = 32'h0BAD_0001; issue_cond = 1'b1; issue_mrc = 1'b0;
    issue_src = 32'h1111_2222;
    @(posedge clk); #1; issue_vld = 1'b0;
    @(posedge clk); #1; cp_hs_dec = HS_WAIT; #1;
    chk("R12 stall before reset", 32'(stall), 32'd1);
    #1; rst = 1'b1; cp_hs_exe = HS_LAST;
    @(posedge clk); #1; rst = 1'b0; #1;
    idle_checks("R12 reset mid");
    @(posedge clk); #2;
    idle_checks("R12 reset mid+1");
    @(posedge clk); #2;
    chk("R12 no commit later", 32'(commit), 32'd0);
    chk("R12 no dout later", cp_dout, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule